// File: doc/BRIEF.md
# Saturating Fixed-Point Requantiser

This block takes a wide signed result, such as a full-precision sum or product, and narrows it to a smaller fixed-point format. A format is written as (total bits, integer bits). The integer bits include the sign, and the rest of the bits are fraction bits. Both the input format and the output format are parameters. The block lines up the binary points and drops the surplus fraction bits, either by rounding to nearest or by truncating toward zero. It then checks whether the shortened value still fits the output's integer range.

When the value does not fit, the block returns the largest positive code or the most negative code, whichever matches the sign of the value. It never lets the value wrap around. A flag marks each sample that was clamped. The result, the flag and a valid strobe come out of one register, one cycle after the input is presented.

The default formats are a 16-bit input with 4 integer bits and an 8-bit output with 2 integer bits. With these defaults, 6 fraction bits are dropped and the output range is −128/64 to +127/64.

Top module: `qnt_requant`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after reset is applied, `out_valid`, `out_ovf` and `out_data` are all 0.
- R2: `out_valid` equals `in_valid` from the previous clock. `out_data` and `out_ovf` describe the sample accepted on that edge.
- R3: With `round_en` = 0, the surplus fraction bits are discarded with truncation toward zero. For the defaults, an in-range result is the input code divided by 64, with the quotient truncated toward zero (−1 gives 0, −95 gives −1).
- R4: With `round_en` = 1, half an output LSB is added before the surplus bits are discarded toward minus infinity. Ties therefore move upward: with the defaults, 96 gives 2, −96 gives −1, and −97 gives −2.
- R5: If the shortened value exceeds the largest output code, `out_data` is that code (0x7F for the defaults) and `out_ovf` is 1.
- R6: If the shortened value is below the most negative output code, `out_data` is that code (0x80 for the defaults) and `out_ovf` is 1.
- R7: An overflow caused only by the rounding increment is also clamped and flagged. For example, 8191 with rounding gives 0x7F with `out_ovf` = 1, while 8191 truncated gives 0x7F with `out_ovf` = 0.
- R8: A value that fits, including exactly the extreme codes (8191 and −8192 truncated), passes through with `out_ovf` = 0. An input of 0 gives 0.
- R9: In a cycle after `in_valid` was low, `out_data` keeps its previous value and `out_ovf` is 0, whatever values `in_data` and `round_en` had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input, IN_INT integer bits |
| round_en | input | 1 | 1 = round to nearest, 0 = truncate toward zero |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | OUT_W | Signed result, OUT_INT integer bits |
| out_ovf | output | 1 | High when the result was clamped to an extreme |

## Verification
The only internal state is the output register, so a fault in it shows at the ports in the very next cycle. A register that is not loaded shows as a held or stale `out_data` beside a fresh `out_valid`. An overflow test on the wrong bits shows as a wrapped code of the wrong sign, or as a flag raised on an exact extreme. A rounding fault shows only on half-LSB ties, on negative truncation, or one LSB below an extreme, so the vector table aims at exactly those codes.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
    typedef enum logic {
        RND_TRUNC = 1'b0,
        RND_NEAR  = 1'b1
    } rnd_mode_e;
endpackage

// File: rtl/qnt_round.sv
module qnt_round #(
    parameter int IN_W  = 16,
    parameter int SHIFT = 6,
    localparam int QW   = IN_W + 1 - SHIFT
) (
    input  logic [IN_W-1:0]   din,
    input  qnt_pkg::rnd_mode_e mode,
    output logic [QW-1:0]     q
);
    logic [IN_W:0] ext;
    assign ext = {din[IN_W-1], din};

    generate
        if (SHIFT > 0) begin : g_drop
            logic [IN_W:0]   half;
            logic [IN_W:0]   sum_near;
            logic            low_nz;
            logic [QW-1:0]   q_trunc;
            always_comb begin
                half     = '0;
                half[SHIFT-1] = 1'b1;
                sum_near = ext + half;
                low_nz   = |din[SHIFT-1:0];
                q_trunc  = ext[IN_W:SHIFT]
                         + {{(QW-1){1'b0}}, (din[IN_W-1] & low_nz)};
                if (mode == qnt_pkg::RND_NEAR) q = sum_near[IN_W:SHIFT];
                else                           q = q_trunc;
            end
        end else begin : g_keep
            assign q = ext;
        end
    endgenerate
endmodule

// File: rtl/qnt_clamp.sv
module qnt_clamp #(
    parameter int QW    = 11,
    parameter int OUT_W = 8,
    localparam int HW   = QW - OUT_W + 1
) (
    input  logic [QW-1:0]    q,
    output logic [OUT_W-1:0] y,
    output logic             ovf
);
    localparam logic [OUT_W-1:0] MAX_C = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_C = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HW-1:0] head;
    always_comb begin
        head = q[QW-1:OUT_W-1];
        ovf  = ~((&head) | ~(|head));
        if (ovf) y = q[QW-1] ? MIN_C : MAX_C;
        else     y = q[OUT_W-1:0];
    end
endmodule

// File: rtl/qnt_requant.sv
module qnt_requant #(
    parameter int IN_W    = 16,
    parameter int IN_INT  = 4,
    parameter int OUT_W   = 8,
    parameter int OUT_INT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             round_en,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_ovf
);
    localparam int IN_FRAC  = IN_W - IN_INT;
    localparam int OUT_FRAC = OUT_W - OUT_INT;
    localparam int SHIFT    = IN_FRAC - OUT_FRAC;
    localparam int QW       = IN_W + 1 - SHIFT;
    localparam logic [OUT_W-1:0] MAX_C = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_C = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic             ovf;
        logic [OUT_W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    logic [QW-1:0]    q_w;
    logic [OUT_W-1:0] y_w;
    logic             ovf_w;
    qnt_pkg::rnd_mode_e mode_w;

    assign mode_w = round_en ? qnt_pkg::RND_NEAR : qnt_pkg::RND_TRUNC;

    qnt_round #(.IN_W(IN_W), .SHIFT(SHIFT)) u_round (
        .din (in_data),
        .mode(mode_w),
        .q   (q_w)
    );

    qnt_clamp #(.QW(QW), .OUT_W(OUT_W)) u_clamp (
        .q  (q_w),
        .y  (y_w),
        .ovf(ovf_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.ovf = 1'b0;
        if (in_valid) begin
            st_d.data = y_w;
            st_d.ovf  = ovf_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_ovf   = st_q.ovf;

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R2
    AST_OVF_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && !$past(in_data[IN_W-1])) |-> out_data == MAX_C); // R5
    AST_OVF_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && $past(in_data[IN_W-1])) |-> out_data == MIN_C); // R6
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(in_data) == '0) |-> (out_data == '0 && !out_ovf)); // R8
    AST_OVF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_ovf); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(out_data)); // R9
endmodule

// File: tb/sim_qnt_requant.sv
`timescale 1ns/100ps
module sim_qnt_requant;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        round_en = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qnt_requant u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .round_en(round_en), .out_valid(out_valid), .out_data(out_data),
        .out_ovf(out_ovf)
    );

    // {input, round_en, expected data, expected ovf}
    localparam int NV = 22;
    localparam logic [25:0] VEC [NV] = '{
        {16'h0000, 1'b0, 8'h00, 1'b0},  // R8
        {16'h0040, 1'b0, 8'h01, 1'b0},  // R3
        {16'h005F, 1'b0, 8'h01, 1'b0},  // R3
        {16'h005F, 1'b1, 8'h01, 1'b0},  // R4
        {16'h0060, 1'b1, 8'h02, 1'b0},  // R4
        {16'hFFA1, 1'b0, 8'hFF, 1'b0},  // R3
        {16'hFFA1, 1'b1, 8'hFF, 1'b0},  // R4
        {16'hFFA0, 1'b1, 8'hFF, 1'b0},  // R4
        {16'hFF9F, 1'b1, 8'hFE, 1'b0},  // R4
        {16'hFFFF, 1'b0, 8'h00, 1'b0},  // R3
        {16'hFFFF, 1'b1, 8'h00, 1'b0},  // R4
        {16'h1FFF, 1'b0, 8'h7F, 1'b0},  // R8
        {16'h1FFF, 1'b1, 8'h7F, 1'b1},  // R7
        {16'h2000, 1'b0, 8'h7F, 1'b1},  // R5
        {16'hE000, 1'b0, 8'h80, 1'b0},  // R8
        {16'hDFFF, 1'b0, 8'h80, 1'b0},  // R3
        {16'hDFC0, 1'b0, 8'h80, 1'b1},  // R6
        {16'h7FFF, 1'b1, 8'h7F, 1'b1},  // R5
        {16'h8000, 1'b0, 8'h80, 1'b1},  // R6
        {16'hDFE0, 1'b1, 8'h80, 1'b0},  // R4
        {16'hDFDF, 1'b1, 8'h80, 1'b1},  // R6
        {16'h0000, 1'b1, 8'h00, 1'b0}   // R8
    };

    function automatic logic [8:0] model(input logic [15:0] d, input logic rnd);
        int v, q;
        v = int'($signed(d));
        if (rnd) q = (v + 32) >>> 6;
        else     q = v / 64;
        if (q > 127)       return {1'b1, 8'h7F};
        else if (q < -128) return {1'b1, 8'h80};
        else               return {1'b0, q[7:0]};
    endfunction

    task automatic check(input string req, input logic [7:0] got_d, input logic got_o,
                         input logic [7:0] exp_d, input logic exp_o);
        checks++;
        if (got_d !== exp_d || got_o !== exp_o) begin
            errors++;
            $display("FAIL %s: data=%h ovf=%b expected data=%h ovf=%b",
                     req, got_d, got_o, exp_d, exp_o);
        end
    endtask

    task automatic apply(input logic [15:0] d, input logic rnd, input string req,
                         input logic [7:0] exp_d, input logic exp_o);
        in_valid = 1'b1; in_data = d; round_en = rnd;
        @(negedge clk);
        check(req, out_data, out_ovf, exp_d, exp_o);
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R2: out_valid=%b expected 1", out_valid);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] m;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", out_data, out_ovf, 8'h00, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++; $display("FAIL R1: out_valid=%b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++)
            apply(VEC[i][25:10], VEC[i][9], "R3/R4/R5/R6/R7/R8", VEC[i][8:1], VEC[i][0]);

        // random sweep plus near-extreme codes
        for (int i = 0; i < 400; i++) begin
            logic [15:0] d;
            logic r;
            d = 16'($urandom);
            if (i % 4 == 1) d = 16'h1FC0 + 16'($urandom_range(0, 127));
            if (i % 4 == 2) d = 16'hDF80 + 16'($urandom_range(0, 127));
            r = 1'($urandom);
            m = model(d, r);
            apply(d, r, "R3/R4/R5/R6", m[7:0], m[8]);
        end

        // R9: idle cycles hold data, flag low, even with overflow input
        apply(16'h7FFF, 1'b0, "R5", 8'h7F, 1'b1);
        apply(16'h0040, 1'b0, "R3", 8'h01, 1'b0);
        held = out_data;
        in_valid = 1'b0; in_data = 16'h8000; round_en = 1'b1;
        @(negedge clk);
        check("R9", out_data, out_ovf, held, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++; $display("FAIL R2: out_valid=%b expected 0", out_valid);
        end
        in_data = 16'h7FFF;
        @(negedge clk);
        check("R9", out_data, out_ovf, held, 1'b0);

        // R1: reset again clears a loaded register
        apply(16'h2000, 1'b0, "R5", 8'h7F, 1'b1);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R1", out_data, out_ovf, 8'h00, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule